// File: doc/BRIEF.md
# Dual-Mode Memory and Time-Slice Protection Unit

This unit sits beside a processor core and enforces the two-level privilege scheme. It holds a one-bit privilege mode, a window start register (`base`), a window size register (`limit`) and a down-counting time-slice timer. In user mode, every memory access address is checked against the window `[base, base+limit)`. Any access outside the window raises an access fault and is not allowed. In monitor mode, every address passes with no check.

Loads of the window registers and the timer are privileged. When the core attempts one in user mode, the unit raises a privilege fault and changes no register. External interrupts, external faults, the unit's own faults and timer expiry all force the mode to monitor. Only an explicit return request puts the core back in user mode. The timer counts down once per clock after a load, and when it hits zero it raises a one-cycle interrupt.

Top module: `prot_unit`

## Requirements
- R1: After reset, the mode is monitor (`mode`=0), no timer interrupt occurs, and `base` and `limit` are 0. Because the window is empty, every user-mode access faults until the window is loaded.
- R2: `mode` encodes monitor as 0 and user as 1. A `set_user` request with no trap in the same cycle makes `mode` 1 from the next cycle on.
- R3: `irq_evt` or `fault_evt` forces `mode` to 0 at the next clock edge, even when `set_user` is present in the same cycle.
- R4: In user mode, a valid access whose address is below `base` gives `acc_fault`=1 and `acc_ok`=0 in the same cycle. The mode becomes monitor at the next edge.
- R5: In user mode, addresses from `base` to `base+limit-1` are allowed, and an address equal to or above `base+limit` faults.
- R6: The window top is computed one bit wider than the address. A window that reaches past the top of the address space allows the highest addresses and does not wrap around to allow low addresses.
- R7: In monitor mode, every valid access gives `acc_ok`=1 and `acc_fault`=0.
- R8: With `acc_vld`=0, both `acc_ok` and `acc_fault` are 0.
- R9: A privileged write (`pw_vld`=1) in user mode gives `priv_fault`=1 in the same cycle and forces monitor mode at the next edge. It leaves `base`, `limit` and the timer unchanged.
- R10: A privileged write in monitor mode takes effect at the next edge. The `pw_op` codes are 00 write base, 01 write limit, 10 load timer and 11 stop timer.
- R11: After a timer load of N>0, `tmr_irq` is 1 for exactly one cycle, which begins N clock edges after the load edge. `mode` is 0 in that same cycle.
- R12: A timer load of 0, or a stop command, leaves the timer stopped. A stopped timer never raises `tmr_irq`.
- R13: An access fault and the final timer tick can fall in the same cycle. In that case `acc_fault` reports the fault in that cycle, `tmr_irq` reports the expiry in the next cycle, and the mode is monitor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_vld | input | 1 | Memory access address valid |
| acc_addr | input | ADDR_W | Memory access address |
| pw_vld | input | 1 | Privileged register write request |
| pw_op | input | 2 | Privileged operation code |
| pw_data | input | ADDR_W | Privileged write data (timer uses the low TMR_W bits) |
| irq_evt | input | 1 | External interrupt event |
| fault_evt | input | 1 | External fault or trap event |
| set_user | input | 1 | Request to return to user mode |
| mode | output | 1 | Current mode: 0 monitor, 1 user |
| acc_ok | output | 1 | Access allowed |
| acc_fault | output | 1 | Access protection fault |
| priv_fault | output | 1 | Privileged write attempted in user mode |
| tmr_irq | output | 1 | Time-slice expiry interrupt (one cycle) |

## Verification
The bench builds the unit with an 8-bit address and a 6-bit timer. With these sizes, a window that starts at 0xF0 with size 0x20 crosses the top of the address space, which exercises the wide-sum check against wrap-around with small constants. The short timer makes every expiry reachable within a few cycles. Reload, stop and zero-load paths, and the coincidence of a final tick with an access fault, are all driven cycle by cycle.

// File: rtl/prot_pkg.sv
// Shared types for the protection unit.
package prot_pkg;

    // Privilege mode; the encoding is visible on the mode port.
    typedef enum logic {
        MODE_MON = 1'b0,
        MODE_USR = 1'b1
    } mode_e;

    // Privileged operation codes carried on pw_op.
    typedef enum logic [1:0] {
        OP_BASE  = 2'b00,
        OP_LIMIT = 2'b01,
        OP_TLOAD = 2'b10,
        OP_TSTOP = 2'b11
    } pw_op_e;

endpackage

// File: rtl/prot_mode_ctl.sv
// Privilege mode register.
// Does: holds the mode bit. Any trap drops it to monitor, and a return request
// with no trap in the same cycle raises it to user.
// Assumes: trap already merges every event that must enter monitor mode.
module prot_mode_ctl
    import prot_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  trap,
    input  logic  set_user,
    output mode_e mode
);

    mode_e mode_q;
    mode_e mode_d;

    // Next mode: a trap wins over a return request.
    always_comb begin
        mode_d = mode_q;
        if (trap) begin
            mode_d = MODE_MON;
        end else if (set_user) begin
            mode_d = MODE_USR;
        end
    end

    // Mode register, monitor after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_MON;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign mode = mode_q;

    // R3
    trap_to_monitor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> (mode == MODE_MON));

    // R2
    return_to_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_user && !trap) |=> (mode == MODE_USR));

endmodule

// File: rtl/prot_bounds.sv
// Window registers and the address check.
// Does: stores the window start and size, and checks user-mode addresses
// against [base, base+limit) with a sum one bit wider than the address.
// Assumes: write enables arrive already qualified by the privilege check.
module prot_bounds #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_base,
    input  logic              wr_limit,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              user,
    input  logic              acc_vld,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              acc_ok,
    output logic              acc_fault
);

    localparam int SUM_W = ADDR_W + 1;

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] limit_q;
    logic [SUM_W-1:0]  top_w;
    logic              above_base;
    logic              below_top;
    logic              in_win;

    // Window start register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (wr_base) begin
            base_q <= wr_data;
        end
    end

    // Window size register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= '0;
        end else if (wr_limit) begin
            limit_q <= wr_data;
        end
    end

    // Window bounds, with the top one bit wide so it cannot wrap.
    always_comb begin
        top_w      = {1'b0, base_q} + {1'b0, limit_q};
        above_base = (acc_addr >= base_q);
        below_top  = ({1'b0, acc_addr} < top_w);
        in_win     = above_base && below_top;
    end

    // Access verdict: monitor mode bypasses the window.
    always_comb begin
        acc_ok    = acc_vld && (!user || in_win);
        acc_fault = acc_vld && user && !in_win;
    end

    // R7
    monitor_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fault |-> user);

    // R8
    verdict_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_ok, acc_fault}) && (acc_vld || !(acc_ok || acc_fault)));

    // R9
    base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_base |=> $stable(base_q));

    // R9
    limit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_limit |=> $stable(limit_q));

endmodule

// File: rtl/prot_slice_timer.sv
// Time-slice down counter.
// Does: after a nonzero load, counts down once per clock. On the tick that
// reaches zero it flags expiry and then raises a registered one-cycle interrupt.
// Assumes: load and stop arrive already qualified by the privilege check. A
// stop wins over a load in the same cycle.
module prot_slice_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             stop,
    input  logic [TMR_W-1:0] load_val,
    output logic             expire,
    output logic             irq
);

    logic [TMR_W-1:0] cnt_q;
    logic             run_q;
    logic             irq_q;

    // Final tick: running at one with no command overriding it.
    always_comb begin
        expire = run_q && (cnt_q == TMR_W'(1)) && !load && !stop;
    end

    // Count and run state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (stop) begin
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= load_val;
            run_q <= (load_val != '0);
        end else if (run_q) begin
            cnt_q <= cnt_q - TMR_W'(1);
            if (cnt_q == TMR_W'(1)) begin
                run_q <= 1'b0;
            end
        end
    end

    // One-cycle interrupt pulse, registered after the final tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= expire;
        end
    end

    assign irq = irq_q;

    // R11
    irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R12
    irq_only_after_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !run_q);

endmodule

// File: rtl/prot_unit.sv
// Dual-mode protection unit top.
// Does: qualifies privileged writes by mode, routes them to the window and
// timer, merges all trap sources and drives the mode register.
// Assumes: pw_data is at least as wide as needed for the timer, otherwise the
// timer load value is zero-extended.
module prot_unit
    import prot_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TMR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_vld,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              pw_vld,
    input  logic [1:0]        pw_op,
    input  logic [ADDR_W-1:0] pw_data,
    input  logic              irq_evt,
    input  logic              fault_evt,
    input  logic              set_user,
    output logic              mode,
    output logic              acc_ok,
    output logic              acc_fault,
    output logic              priv_fault,
    output logic              tmr_irq
);

    localparam bit TMR_FITS = (TMR_W <= ADDR_W);

    mode_e            mode_st;
    logic             user;
    logic             pw_ok;
    logic             wr_base;
    logic             wr_limit;
    logic             t_load;
    logic             t_stop;
    logic             t_expire;
    logic             trap;
    logic [TMR_W-1:0] t_val;

    assign user = (mode_st == MODE_USR);
    assign mode = user;

    // Privilege qualification and operation decode.
    always_comb begin
        pw_ok      = pw_vld && !user;
        priv_fault = pw_vld && user;
        wr_base    = pw_ok && (pw_op == OP_BASE);
        wr_limit   = pw_ok && (pw_op == OP_LIMIT);
        t_load     = pw_ok && (pw_op == OP_TLOAD);
        t_stop     = pw_ok && (pw_op == OP_TSTOP);
    end

    // Timer load value, sliced or widened from the write data.
    generate
        if (TMR_FITS) begin : g_tval_slice
            assign t_val = pw_data[TMR_W-1:0];
        end else begin : g_tval_ext
            assign t_val = TMR_W'(pw_data);
        end
    endgenerate

    // Every source that must enter monitor mode.
    always_comb begin
        trap = irq_evt || fault_evt || acc_fault || priv_fault || t_expire;
    end

    prot_mode_ctl u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .trap     (trap),
        .set_user (set_user),
        .mode     (mode_st)
    );

    prot_bounds #(.ADDR_W(ADDR_W)) u_bounds (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_base   (wr_base),
        .wr_limit  (wr_limit),
        .wr_data   (pw_data),
        .user      (user),
        .acc_vld   (acc_vld),
        .acc_addr  (acc_addr),
        .acc_ok    (acc_ok),
        .acc_fault (acc_fault)
    );

    prot_slice_timer #(.TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .stop     (t_stop),
        .load_val (t_val),
        .expire   (t_expire),
        .irq      (tmr_irq)
    );

    // R11
    irq_in_monitor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_irq |-> !mode);

    // R9
    priv_fault_traps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        priv_fault |=> !mode);

    // R4
    access_fault_traps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fault |=> !mode);

endmodule

// File: tb/tb_prot_unit.sv
// Scoreboard bench: the driver applies one cycle of stimulus and pushes the
// expected outputs {mode, acc_ok, acc_fault, priv_fault, tmr_irq}; the monitor
// pops and compares shortly after each falling edge.
module tb_prot_unit;

    localparam int CLK_P  = 10;
    localparam int ADDR_W = 8;
    localparam int TMR_W  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acc_vld = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic              pw_vld = 1'b0;
    logic [1:0]        pw_op = '0;
    logic [ADDR_W-1:0] pw_data = '0;
    logic              irq_evt = 1'b0;
    logic              fault_evt = 1'b0;
    logic              set_user = 1'b0;
    logic              mode;
    logic              acc_ok;
    logic              acc_fault;
    logic              priv_fault;
    logic              tmr_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [4:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_P/2) clk = ~clk;

    prot_unit #(.ADDR_W(ADDR_W), .TMR_W(TMR_W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_vld    (acc_vld),
        .acc_addr   (acc_addr),
        .pw_vld     (pw_vld),
        .pw_op      (pw_op),
        .pw_data    (pw_data),
        .irq_evt    (irq_evt),
        .fault_evt  (fault_evt),
        .set_user   (set_user),
        .mode       (mode),
        .acc_ok     (acc_ok),
        .acc_fault  (acc_fault),
        .priv_fault (priv_fault),
        .tmr_irq    (tmr_irq)
    );

    // One cycle of stimulus plus its expected outputs.
    task automatic cyc(input logic av, input logic [7:0] aa, input logic pv,
                       input logic [1:0] op, input logic [7:0] pd,
                       input logic ie, input logic fe, input logic su,
                       input logic [4:0] ex, input string tg);
        @(negedge clk);
        acc_vld = av; acc_addr = aa; pw_vld = pv; pw_op = op; pw_data = pd;
        irq_evt = ie; fault_evt = fe; set_user = su;
        exp_q.push_back(ex);
        tag_q.push_back(tg);
    endtask

    task automatic idle(input logic su, input logic [4:0] ex, input string tg);
        cyc(0, 8'h00, 0, 2'b00, 8'h00, 0, 0, su, ex, tg);
    endtask

    task automatic acc(input logic [7:0] a, input logic su, input logic [4:0] ex,
                       input string tg);
        cyc(1, a, 0, 2'b00, 8'h00, 0, 0, su, ex, tg);
    endtask

    task automatic pw(input logic [1:0] op, input logic [7:0] d,
                      input logic [4:0] ex, input string tg);
        cyc(0, 8'h00, 1, op, d, 0, 0, 0, ex, tg);
    endtask

    // Monitor: compare one expected item per cycle.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [4:0] act;
                logic [4:0] ex;
                string      tg;
                act = {mode, acc_ok, acc_fault, priv_fault, tmr_irq};
                ex  = exp_q.pop_front();
                tg  = tag_q.pop_front();
                checks++;
                if (act !== ex) begin
                    errors++;
                    $display("FAIL %s: {mode,ok,flt,pflt,irq} actual %b expected %b",
                             tg, act, ex);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Driver sequence.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(0, 5'b00000, "R1 reset state");
        acc(8'h55, 0, 5'b01000, "R7 monitor bypass");
        acc(8'h00, 1, 5'b01000, "R2 still monitor");
        acc(8'h00, 0, 5'b10100, "R1 empty window faults");
        idle(0, 5'b00000, "R4 fault enters monitor");
        pw(2'b00, 8'h20, 5'b00000, "R10 write base");
        pw(2'b01, 8'h10, 5'b00000, "R10 write limit");
        idle(1, 5'b00000, "R2 request user");
        acc(8'h1F, 0, 5'b10100, "R4 below base");
        idle(1, 5'b00000, "R4 monitor after fault");
        acc(8'h20, 0, 5'b11000, "R5 base allowed");
        acc(8'h2F, 0, 5'b11000, "R5 last legal");
        acc(8'h30, 0, 5'b10100, "R5 at top faults");
        idle(1, 5'b00000, "R5 monitor after fault");
        cyc(0, 8'h30, 0, 2'b00, 8'h00, 0, 0, 0, 5'b10000, "R8 no valid no verdict");
        pw(2'b00, 8'h00, 5'b10010, "R9 user write base");
        acc(8'h1F, 1, 5'b01000, "R9 monitor after priv fault");
        acc(8'h1F, 0, 5'b10100, "R9 base unchanged");
        pw(2'b00, 8'hF0, 5'b00000, "R10 base F0");
        pw(2'b01, 8'h20, 5'b00000, "R10 limit 20");
        idle(1, 5'b00000, "R6 request user");
        acc(8'hFF, 0, 5'b11000, "R6 top address legal");
        acc(8'hF0, 0, 5'b11000, "R6 window start legal");
        acc(8'h05, 0, 5'b10100, "R6 no wrap");
        cyc(0, 8'h00, 0, 2'b00, 8'h00, 1, 0, 1, 5'b00000, "R3 irq with return");
        idle(1, 5'b00000, "R3 irq beat return");
        cyc(0, 8'h00, 0, 2'b00, 8'h00, 0, 1, 0, 5'b10000, "R3 user before fault");
        pw(2'b10, 8'h03, 5'b00000, "R3 fault event to monitor");
        idle(1, 5'b00000, "R11 count 3");
        idle(0, 5'b10000, "R11 count 2");
        idle(0, 5'b10000, "R11 count 1 no irq");
        idle(0, 5'b00001, "R11 irq and monitor");
        pw(2'b10, 8'h00, 5'b00000, "R11 single pulse");
        for (int i = 0; i < 4; i++) idle(0, 5'b00000, "R12 zero load stopped");
        pw(2'b10, 8'h04, 5'b00000, "R12 load 4");
        pw(2'b11, 8'h00, 5'b00000, "R12 stop");
        for (int i = 0; i < 6; i++) idle(0, 5'b00000, "R12 stopped no irq");
        pw(2'b10, 8'h02, 5'b00000, "R13 load 2");
        idle(1, 5'b00000, "R13 request user");
        acc(8'h05, 0, 5'b10100, "R13 fault on last tick");
        idle(0, 5'b00001, "R13 expiry reported");
        idle(1, 5'b00000, "R9 request user");
        pw(2'b10, 8'h02, 5'b10010, "R9 user timer load");
        for (int i = 0; i < 4; i++) idle(0, 5'b00000, "R9 timer untouched");
        @(negedge clk);
        #5;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule